// File: doc/BRIEF.md
# Debug-port access scan register

This block is the data-register side of a JTAG debug port. A separate TAP controller owns the test-mode sequencing and delivers, on clean ports, the current 4-bit instruction together with one-cycle capture, shift and update strobes. The block selects a data register from the instruction. The choices are an identification word, a 1-bit bypass stage, or a 35-bit access register. That access register carries debug-port requests, access-port requests and abort requests.

An access scan shifts in three low bits first: a read/not-write flag and a two-bit register address. Thirty-two data bits follow. At capture, the same three bits return an acknowledge code and the data bits return the result of the previous read, because reads are posted. The debug port holds a control/status word, a bank/port select word and a read buffer. Access-port requests go to a small internal register bank. The bank stays busy for a set number of TCK cycles per request. An access scanned while the bank is busy is answered with WAIT and dropped. If overrun detection is on, that WAIT also raises a sticky overrun flag. An access-port request to a missing port or register raises a sticky error. While either sticky flag is up, access-port requests are discarded. An abort request cancels a pending bank transaction.

The bank is driven by a two-state machine. AP_IDLE moves to AP_BUSY on the *issue* transition, when a request is accepted. AP_BUSY returns to AP_IDLE on the *finish* transition, when its countdown expires and the write lands or the read result is posted. AP_BUSY also returns to AP_IDLE on the *cancel* transition, when an abort arrives, and then nothing is committed.

Top module: `dbg_scan_port`

## Requirements
- R1: Instruction 4'hE selects a 32-bit register that captures the IDCODE parameter. Instructions 4'h8, 4'hA and 4'hB select the 35-bit access register. Any other code selects a 1-bit bypass stage that captures 0 and delays tdi by one shift.
- R2: In the access register, bit 0 is read-not-write (1 = read), bits 2:1 are the register address and bits 34:3 are data. tdo presents bit 0 first. When no bank transaction is pending, a capture under 4'hA or 4'hB returns acknowledge 3'b010 in bits 2:0.
- R3: Reads are posted. The data field captured by any access scan is the read buffer, so it holds the result of the last completed read. Debug-port address 1 reads control/status and address 2 reads select. An access-port read lands in the read buffer when the bank finishes.
- R4: A debug-port read of address 3 returns the read buffer and leaves it unchanged, so repeated reads return the same value.
- R5: Each accepted access-port request keeps the bank busy for AP_LATENCY TCK cycles. A capture under 4'hA or 4'hB during that time returns 3'b001 (WAIT) with data 0. The access scanned in that WAIT scan is dropped and does not take effect.
- R6: A dropped access sets the sticky overrun flag (control/status bit 1) only while overrun detection (bit 0) is set.
- R7: While sticky overrun or sticky error is set, access-port requests are discarded and start no bank transaction.
- R8: Writing control/status with bit 1 or bit 5 set to 1 clears the matching sticky flag. Bit 0 is written directly.
- R9: Select bits 31:24 name the access port and bits 7:4 the bank. The register index is {select[7:4], address}. An access-port request to a port other than AP_NUM, or to an index of AP_DEPTH or above, sets sticky error (control/status bit 5) and starts nothing.
- R10: An update under 4'h8 whose data field equals 1 cancels a pending bank transaction, so its write is not applied. Any other data value has no effect.
- R11: Control/status bits 28 and 30 are power-up requests written by software. Bits 29 and 31 are their acknowledges and follow the requests one TCK later.
- R12: After reset, control/status, select, the read buffer and every bank register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 4 | Current instruction from the TAP |
| capture_dr | input | 1 | Capture strobe for the selected data register |
| shift_dr | input | 1 | Shift strobe for the selected data register |
| update_dr | input | 1 | Update strobe for the selected data register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the selected register) |

## Verification
A table of access scans first walks debug-port writes and reads, then spaced access-port writes and reads, then sticky flag setup and clearing. Each captured data field can only match if the posted result came from the expected earlier read, so this pattern separates posted results from immediate ones. Back-to-back scans after an access-port request force WAIT. Those scans show whether the dropped access really vanished and whether the overrun flag obeys its enable. Abort scans with data 1 and data 2 show cancellation apart from no effect. Identification and bypass scans check the register length chosen for each instruction.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    localparam int DR_W = 35;
    localparam int ID_W = 32;

    localparam logic [3:0] IR_ABORT  = 4'h8;
    localparam logic [3:0] IR_DPACC  = 4'hA;
    localparam logic [3:0] IR_APACC  = 4'hB;
    localparam logic [3:0] IR_IDCODE = 4'hE;

    localparam logic [2:0] ACK_OK   = 3'b010;
    localparam logic [2:0] ACK_WAIT = 3'b001;

    localparam logic [1:0] DPA_NONE  = 2'd0;
    localparam logic [1:0] DPA_CTRL  = 2'd1;
    localparam logic [1:0] DPA_SEL   = 2'd2;
    localparam logic [1:0] DPA_RDBUF = 2'd3;

    localparam int CS_ORUN_EN = 0;
    localparam int CS_ORUN    = 1;
    localparam int CS_ERR     = 5;
    localparam int CS_DBG_REQ = 28;
    localparam int CS_DBG_ACK = 29;
    localparam int CS_SYS_REQ = 30;
    localparam int CS_SYS_ACK = 31;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_ACCESS} dr_sel_e;
    typedef enum logic {AP_IDLE, AP_BUSY} ap_state_e;

    typedef struct packed {
        logic [31:0] data;
        logic [1:0]  addr;
        logic        rnw;
    } acc_word_t;
endpackage

// File: rtl/dsp_scan_path.sv
module dsp_scan_path
    import dsp_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  dr_sel_e         sel,
    input  logic            capture,
    input  logic            shift,
    input  logic [DR_W-1:0] cap_word,
    input  logic            tdi,
    output logic            tdo,
    output logic [DR_W-1:0] sr_q
);
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (capture) begin
            sr_q <= cap_word;
        end else if (shift) begin
            unique case (sel)
                DR_ACCESS: sr_q <= {tdi, sr_q[DR_W-1:1]};
                DR_IDCODE: sr_q[ID_W-1:0] <= {tdi, sr_q[ID_W-1:1]};
                DR_BYPASS: sr_q[0] <= tdi;
                default:   sr_q <= sr_q;
            endcase
        end
    end

    assign tdo = sr_q[0];
endmodule

// File: rtl/dsp_ap_bank.sv
module dsp_ap_bank
    import dsp_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int LATENCY = 8,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(LATENCY + 1)
) (
    input  logic          tck,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_rnw,
    input  logic [AW-1:0] req_idx,
    input  logic [31:0]   req_wdata,
    input  logic          abort,
    output logic          busy,
    output logic          done_rd,
    output logic [31:0]   rdata
);
    ap_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             p_rnw_q;
    logic [AW-1:0]    p_idx_q;
    logic [31:0]      p_wdata_q;
    logic [31:0]      mem_q [DEPTH];
    logic             finish;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= AP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AP_IDLE: if (req) state_d = AP_BUSY;
            AP_BUSY: begin
                if (abort)           state_d = AP_IDLE;
                else if (cnt_q == 0) state_d = AP_IDLE;
            end
            default: state_d = AP_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state_q == AP_BUSY);
        finish  = busy && !abort && (cnt_q == 0);
        done_rd = finish && p_rnw_q;
        rdata   = mem_q[p_idx_q];
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            p_rnw_q   <= 1'b0;
            p_idx_q   <= '0;
            p_wdata_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (req && !busy) begin
                cnt_q     <= CNT_W'(LATENCY - 1);
                p_rnw_q   <= req_rnw;
                p_idx_q   <= req_idx;
                p_wdata_q <= req_wdata;
            end else if (busy && cnt_q != 0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (finish && !p_rnw_q) mem_q[p_idx_q] <= p_wdata_q;
        end
    end

    assert_req_only_idle_R5: assert property (@(posedge tck) disable iff (!rst_n)
        req |-> !busy);
    assert_busy_from_req_R5: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(busy) |-> $past(req));
endmodule

// File: rtl/dsp_dp_ctrl.sv
module dsp_dp_ctrl
    import dsp_pkg::*;
#(
    parameter int AP_NUM = 0,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IDX_W = 6
) (
    input  logic          tck,
    input  logic          rst_n,
    input  logic          cap_acc,
    input  logic          upd_dp,
    input  logic          upd_ap,
    input  logic          upd_abort,
    input  acc_word_t     word,
    input  logic          ap_busy,
    input  logic          ap_done_rd,
    input  logic [31:0]   ap_rdata,
    output logic [31:0]   rdbuf,
    output logic [31:0]   ctrlstat,
    output logic          ap_req,
    output logic [AW-1:0] ap_idx,
    output logic          ap_abort
);
    logic        waited_q;
    logic        orun_en_q, orun_q, err_q;
    logic        dbg_req_q, dbg_ack_q, sys_req_q, sys_ack_q;
    logic [31:0] select_q, rdbuf_q;
    logic [IDX_W-1:0] full_idx;
    logic        dp_go, ap_go, wait_drop, sticky_any, ap_ok, ap_bad;

    always_comb begin
        dp_go      = upd_dp && !waited_q;
        ap_go      = upd_ap && !waited_q;
        wait_drop  = (upd_dp || upd_ap) && waited_q;
        sticky_any = orun_q || err_q;
        full_idx   = {select_q[7:4], word.addr};
        ap_ok      = (select_q[31:24] == 8'(AP_NUM)) && (int'(full_idx) < DEPTH);
        ap_req     = ap_go && !sticky_any && ap_ok;
        ap_bad     = ap_go && !sticky_any && !ap_ok;
        ap_idx     = full_idx[AW-1:0];
        ap_abort   = upd_abort && (word.data == 32'd1);
        ctrlstat   = '0;
        ctrlstat[CS_ORUN_EN] = orun_en_q;
        ctrlstat[CS_ORUN]    = orun_q;
        ctrlstat[CS_ERR]     = err_q;
        ctrlstat[CS_DBG_REQ] = dbg_req_q;
        ctrlstat[CS_DBG_ACK] = dbg_ack_q;
        ctrlstat[CS_SYS_REQ] = sys_req_q;
        ctrlstat[CS_SYS_ACK] = sys_ack_q;
        rdbuf      = rdbuf_q;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            waited_q  <= 1'b0;
            orun_en_q <= 1'b0;
            orun_q    <= 1'b0;
            err_q     <= 1'b0;
            dbg_req_q <= 1'b0;
            dbg_ack_q <= 1'b0;
            sys_req_q <= 1'b0;
            sys_ack_q <= 1'b0;
            select_q  <= '0;
            rdbuf_q   <= '0;
        end else begin
            dbg_ack_q <= dbg_req_q;
            sys_ack_q <= sys_req_q;
            if (cap_acc) waited_q <= ap_busy;
            if (wait_drop && orun_en_q) orun_q <= 1'b1;
            if (ap_bad) err_q <= 1'b1;
            if (dp_go && !word.rnw) begin
                if (word.addr == DPA_CTRL) begin
                    orun_en_q <= word.data[CS_ORUN_EN];
                    dbg_req_q <= word.data[CS_DBG_REQ];
                    sys_req_q <= word.data[CS_SYS_REQ];
                    if (word.data[CS_ORUN]) orun_q <= 1'b0;
                    if (word.data[CS_ERR])  err_q  <= 1'b0;
                end else if (word.addr == DPA_SEL) begin
                    select_q <= word.data;
                end
            end
            if (ap_done_rd) begin
                rdbuf_q <= ap_rdata;
            end else if (dp_go && word.rnw) begin
                unique case (word.addr)
                    DPA_CTRL:  rdbuf_q <= ctrlstat;
                    DPA_SEL:   rdbuf_q <= select_q;
                    DPA_RDBUF: rdbuf_q <= rdbuf_q;
                    DPA_NONE:  rdbuf_q <= '0;
                    default:   rdbuf_q <= rdbuf_q;
                endcase
            end
        end
    end

    assert_wait_keeps_select_R5: assert property (@(posedge tck) disable iff (!rst_n)
        wait_drop |=> $stable(select_q));
    assert_rdbuf_no_side_effect_R4: assert property (@(posedge tck) disable iff (!rst_n)
        (dp_go && word.rnw && word.addr == DPA_RDBUF && !ap_done_rd) |=> $stable(rdbuf_q));
    assert_power_ack_follows_R11: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(dbg_req_q) |=> dbg_ack_q);
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
    import dsp_pkg::*;
#(
    parameter logic [31:0] IDCODE     = 32'h4C0F_F0A3,
    parameter int          AP_NUM     = 0,
    parameter int          AP_DEPTH   = 8,
    parameter int          AP_LATENCY = 8,
    localparam int         AW         = (AP_DEPTH > 1) ? $clog2(AP_DEPTH) : 1
) (
    input  logic       tck,
    input  logic       rst_n,
    input  logic [3:0] ir,
    input  logic       capture_dr,
    input  logic       shift_dr,
    input  logic       update_dr,
    input  logic       tdi,
    output logic       tdo
);
    dr_sel_e         sel;
    logic [DR_W-1:0] cap_word, sr_q;
    logic            is_acc, cap_acc;
    acc_word_t       word;
    logic [31:0]     rdbuf, ctrlstat, ap_rdata;
    logic            ap_req, ap_abort, ap_busy, ap_done_rd;
    logic [AW-1:0]   ap_idx;

    always_comb begin
        unique case (ir)
            IR_IDCODE:                   sel = DR_IDCODE;
            IR_ABORT, IR_DPACC, IR_APACC: sel = DR_ACCESS;
            default:                     sel = DR_BYPASS;
        endcase
        is_acc  = (ir == IR_DPACC) || (ir == IR_APACC);
        cap_acc = capture_dr && is_acc;
        word    = acc_word_t'(sr_q);
        unique case (sel)
            DR_IDCODE: cap_word = {{(DR_W-ID_W){1'b0}}, IDCODE};
            DR_ACCESS: begin
                if (!is_acc)      cap_word = {32'b0, ACK_OK};
                else if (ap_busy) cap_word = {32'b0, ACK_WAIT};
                else              cap_word = {rdbuf, ACK_OK};
            end
            default:   cap_word = '0;
        endcase
    end

    dsp_scan_path u_path (
        .tck(tck), .rst_n(rst_n), .sel(sel), .capture(capture_dr),
        .shift(shift_dr), .cap_word(cap_word), .tdi(tdi), .tdo(tdo), .sr_q(sr_q)
    );

    dsp_dp_ctrl #(.AP_NUM(AP_NUM), .DEPTH(AP_DEPTH)) u_ctrl (
        .tck(tck), .rst_n(rst_n), .cap_acc(cap_acc),
        .upd_dp(update_dr && ir == IR_DPACC),
        .upd_ap(update_dr && ir == IR_APACC),
        .upd_abort(update_dr && ir == IR_ABORT),
        .word(word), .ap_busy(ap_busy), .ap_done_rd(ap_done_rd), .ap_rdata(ap_rdata),
        .rdbuf(rdbuf), .ctrlstat(ctrlstat), .ap_req(ap_req), .ap_idx(ap_idx),
        .ap_abort(ap_abort)
    );

    dsp_ap_bank #(.DEPTH(AP_DEPTH), .LATENCY(AP_LATENCY)) u_bank (
        .tck(tck), .rst_n(rst_n), .req(ap_req), .req_rnw(word.rnw), .req_idx(ap_idx),
        .req_wdata(word.data), .abort(ap_abort), .busy(ap_busy),
        .done_rd(ap_done_rd), .rdata(ap_rdata)
    );

    assert_ack_code_R2: assert property (@(posedge tck) disable iff (!rst_n)
        cap_acc |=> (sr_q[2:0] == ACK_OK || sr_q[2:0] == ACK_WAIT));
    assert_sticky_blocks_ap_R7: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(ap_busy) |-> !$past(ctrlstat[CS_ORUN] || ctrlstat[CS_ERR]));
endmodule

// File: tb/tb_dbg_scan_port.sv
`timescale 1ns/1ps
module tb_dbg_scan_port;
    localparam logic [31:0] ID  = 32'h4C0F_F0A3;
    localparam int          LAT = 60;
    localparam logic [3:0]  DP  = 4'hA;
    localparam logic [3:0]  AP  = 4'hB;
    localparam logic [2:0]  OK  = 3'b010;
    localparam logic [2:0]  WT  = 3'b001;

    logic tck = 1'b0, rst_n = 1'b0;
    logic [3:0] ir = 4'hF;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo;
    int checks = 0, errors = 0;

    always #2 tck = ~tck;

    dbg_scan_port #(.IDCODE(ID), .AP_NUM(0), .AP_DEPTH(8), .AP_LATENCY(LAT)) dut (
        .tck(tck), .rst_n(rst_n), .ir(ir), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [3:0]  irv;
        logic        rnw;
        logic [1:0]  a;
        logic [31:0] wd;
        logic [7:0]  idle;
        logic [2:0]  eack;
        logic [31:0] ed;
    } vec_t;

    localparam vec_t VEC [33] = '{
        '{"R12", DP, 1'b0, 2'd2, 32'h0000_0010, 8'd2,  OK, 32'h0},
        '{"R12", DP, 1'b1, 2'd2, 32'h0,         8'd2,  OK, 32'h0},
        '{"R3 ", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'h0000_0010},
        '{"R4 ", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'h0000_0010},
        '{"R11", DP, 1'b0, 2'd1, 32'h5000_0001, 8'd2,  OK, 32'h0000_0010},
        '{"R3 ", DP, 1'b1, 2'd1, 32'h0,         8'd2,  OK, 32'h0000_0010},
        '{"R11", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'hF000_0001},
        '{"R2 ", AP, 1'b0, 2'd1, 32'hCAFE_0005, 8'd80, OK, 32'hF000_0001},
        '{"R2 ", AP, 1'b1, 2'd1, 32'h0,         8'd80, OK, 32'hF000_0001},
        '{"R3 ", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'hCAFE_0005},
        '{"R3 ", AP, 1'b1, 2'd0, 32'h0,         8'd0,  OK, 32'hCAFE_0005},
        '{"R5 ", DP, 1'b1, 2'd1, 32'h0,         8'd80, WT, 32'h0},
        '{"R12", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'h0},
        '{"R5 ", DP, 1'b1, 2'd1, 32'h0,         8'd2,  OK, 32'h0},
        '{"R6 ", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'hF000_0003},
        '{"R7 ", AP, 1'b0, 2'd1, 32'h0000_1234, 8'd80, OK, 32'hF000_0003},
        '{"R8 ", DP, 1'b0, 2'd1, 32'h5000_0003, 8'd2,  OK, 32'hF000_0003},
        '{"R7 ", AP, 1'b1, 2'd1, 32'h0,         8'd80, OK, 32'hF000_0003},
        '{"R7 ", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'hCAFE_0005},
        '{"R9 ", DP, 1'b0, 2'd2, 32'h0100_0010, 8'd2,  OK, 32'hCAFE_0005},
        '{"R9 ", AP, 1'b1, 2'd0, 32'h0,         8'd80, OK, 32'hCAFE_0005},
        '{"R9 ", DP, 1'b1, 2'd1, 32'h0,         8'd2,  OK, 32'hCAFE_0005},
        '{"R9 ", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'hF000_0021},
        '{"R8 ", DP, 1'b0, 2'd1, 32'h5000_0021, 8'd2,  OK, 32'hF000_0021},
        '{"R9 ", DP, 1'b0, 2'd2, 32'h0000_0020, 8'd2,  OK, 32'hF000_0021},
        '{"R3 ", DP, 1'b1, 2'd2, 32'h0,         8'd2,  OK, 32'hF000_0021},
        '{"R9 ", AP, 1'b0, 2'd0, 32'hDEAD_0000, 8'd80, OK, 32'h0000_0020},
        '{"R9 ", DP, 1'b1, 2'd1, 32'h0,         8'd2,  OK, 32'h0000_0020},
        '{"R9 ", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'hF000_0021},
        '{"R8 ", DP, 1'b0, 2'd1, 32'h5000_0021, 8'd2,  OK, 32'hF000_0021},
        '{"R9 ", DP, 1'b0, 2'd2, 32'h0000_0010, 8'd2,  OK, 32'hF000_0021},
        '{"R8 ", DP, 1'b1, 2'd1, 32'h0,         8'd2,  OK, 32'hF000_0021},
        '{"R8 ", DP, 1'b1, 2'd3, 32'h0,         8'd2,  OK, 32'hF000_0001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [3:0] irv, input int len, input logic [34:0] din,
                        input int idle, output logic [34:0] dout);
        dout = '0;
        @(negedge tck); ir = irv; capture_dr = 1'b1;
        @(negedge tck); capture_dr = 1'b0;
        for (int i = 0; i < len; i++) begin
            shift_dr = 1'b1; tdi = din[i]; dout[i] = tdo;
            @(negedge tck);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge tck); update_dr = 1'b0;
        repeat (idle) @(negedge tck);
    endtask

    task automatic acc(input logic [3:0] irv, input logic rnw, input logic [1:0] a,
                       input logic [31:0] wd, input int idle,
                       output logic [2:0] ack, output logic [31:0] d);
        logic [34:0] o;
        scan(irv, 35, {wd, a, rnw}, idle, o);
        ack = o[2:0];
        d   = o[34:3];
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0]  ack;
        logic [31:0] d;
        logic [34:0] o;
        repeat (3) @(negedge tck);
        rst_n = 1'b1;
        @(negedge tck);
        check("R12 tdo after reset", {31'b0, tdo}, 32'h0);

        for (int k = 0; k < 33; k++) begin
            acc(VEC[k].irv, VEC[k].rnw, VEC[k].a, VEC[k].wd, int'(VEC[k].idle), ack, d);
            check($sformatf("%s ack vec%0d", VEC[k].tag, k), {29'b0, ack}, {29'b0, VEC[k].eack});
            check($sformatf("%s data vec%0d", VEC[k].tag, k), d, VEC[k].ed);
        end

        // R10: abort with data 1 cancels a pending write
        acc(AP, 1'b0, 2'd1, 32'h0BAD_0005, 0, ack, d);
        acc(4'h8, 1'b0, 2'd0, 32'h1, 2, ack, d);
        acc(AP, 1'b1, 2'd1, 32'h0, 80, ack, d);
        check("R10 no wait after abort", {29'b0, ack}, {29'b0, OK});
        acc(DP, 1'b1, 2'd3, 32'h0, 2, ack, d);
        check("R10 cancelled write not applied", d, 32'hCAFE_0005);

        // R10: abort with another value is ignored
        acc(AP, 1'b0, 2'd1, 32'h0BAD_0005, 0, ack, d);
        acc(4'h8, 1'b0, 2'd0, 32'h2, 0, ack, d);
        acc(DP, 1'b1, 2'd1, 32'h0, 80, ack, d);
        check("R10 still busy after abort=2", {29'b0, ack}, {29'b0, WT});
        acc(DP, 1'b0, 2'd1, 32'h5000_0003, 2, ack, d);
        acc(AP, 1'b1, 2'd1, 32'h0, 80, ack, d);
        acc(DP, 1'b1, 2'd3, 32'h0, 2, ack, d);
        check("R10 write kept after abort=2", d, 32'h0BAD_0005);

        // R6: overrun detection off leaves sticky overrun clear
        acc(DP, 1'b0, 2'd1, 32'h5000_0000, 2, ack, d);
        acc(AP, 1'b1, 2'd0, 32'h0, 0, ack, d);
        acc(DP, 1'b1, 2'd1, 32'h0, 80, ack, d);
        check("R5 wait ack", {29'b0, ack}, {29'b0, WT});
        check("R5 wait data zero", d, 32'h0);
        acc(DP, 1'b1, 2'd1, 32'h0, 2, ack, d);
        check("R3 posted bank read", d, 32'h0);
        acc(DP, 1'b1, 2'd3, 32'h0, 2, ack, d);
        check("R6 no overrun when disabled", d, 32'hF000_0000);

        // R11: dropping requests drops acks
        acc(DP, 1'b0, 2'd1, 32'h0, 2, ack, d);
        acc(DP, 1'b1, 2'd1, 32'h0, 2, ack, d);
        acc(DP, 1'b1, 2'd3, 32'h0, 2, ack, d);
        check("R11 power cleared", d, 32'h0);

        // R1: identification and bypass
        scan(4'hE, 32, 35'h0, 2, o);
        check("R1 idcode", o[31:0], ID);
        scan(4'hF, 2, 35'h3, 2, o);
        check("R1 bypass 4'hF", {30'b0, o[1:0]}, 32'h2);
        scan(4'h3, 2, 35'h3, 2, o);
        check("R1 bypass 4'h3", {30'b0, o[1:0]}, 32'h2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule